// File: doc/BRIEF.md
# Link Device-Sleep Timeout Controller

This block decides when a storage host port drives its device-sleep (DEVSLP) sideband line high and when it lets it go. It counts a 1 ms timebase tick, which arrives as a single-cycle strobe. From that count it measures three windows. The first is how long the port has been idle. The second is how long DEVSLP has been held. The third is how long the device has had to recover since release. Each window is compared against a configuration field.

Sleep is entered in one of two ways. Software can ask for it with a request pulse. The block can also enter on its own: when the automatic path is enabled, DEVSLP goes high once the port has stayed idle for a programmed count multiplied by a 0-based multiplier. Once high, DEVSLP is held for at least a minimum number of ticks. After that, a wake pulse or the clearing of the automatic-enable bit releases it. After release the block waits out an exit window. When the window ends it emits a one-cycle ready pulse, which tells the surrounding logic that the device can take out-of-band signalling again. Sleep requests that arrive inside the exit window are dropped.

The configuration fields are plain inputs. The usual power-on setting is multiplier code 15, idle count 4, minimum hold 10, exit window 20, platform support 1 and automatic enable 0.

Top module: `devslp_timeout_ctrl`

## Requirements
- R1: With `cfg_platform_ok`=1 and `cfg_auto_en`=1, suppose `port_idle` stays high. DEVSLP then rises after exactly `cfg_idle_cnt` × (`cfg_idle_mult` + 1) ticks, counted from the moment `port_idle` went high. The rise happens within two clock cycles of the last of those ticks.
- R2: If `port_idle` drops for any cycle before the idle target is reached, the idle count starts again from zero.
- R3: Once DEVSLP is high, it stays high for exactly `cfg_min_hold` ticks when a release request arrives earlier than that. A release request made during the hold is remembered, and it takes effect within two cycles of the tick that completes the hold.
- R4: If `cfg_auto_en`=0, or if `cfg_platform_ok`=0, an idle port never raises DEVSLP, however many ticks pass.
- R5: A one-cycle `sw_sleep_req` pulse, given while awake and not in the exit window, raises DEVSLP within two cycles. This holds whatever the automatic-enable and platform flags are.
- R6: Suppose the hold has completed. Then a `sw_wake_req` pulse, or a 1→0 change of `cfg_auto_en`, drops DEVSLP within two cycles. Without one of these, DEVSLP stays high.
- R7: After DEVSLP drops, `exit_ready` pulses high for exactly one cycle. The pulse comes within two cycles of the `cfg_exit_win`-th tick counted after the drop.
- R8: A `sw_sleep_req` pulse during the exit window is ignored. DEVSLP stays low, and the exit window still ends after its full tick count.
- R9: After reset, `devslp` and `exit_ready` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | Single-cycle 1 ms timebase strobe |
| port_idle | input | 1 | Port has no outstanding activity |
| sw_sleep_req | input | 1 | Software sleep request pulse |
| sw_wake_req | input | 1 | Software wake request pulse |
| cfg_idle_cnt | input | 10 | Idle timeout count in ticks |
| cfg_idle_mult | input | 4 | 0-based idle timeout multiplier |
| cfg_min_hold | input | 5 | Minimum DEVSLP assertion in ticks |
| cfg_exit_win | input | 8 | Exit window in ticks |
| cfg_platform_ok | input | 1 | Platform supports device sleep on this port |
| cfg_auto_en | input | 1 | Automatic (idle-timer) entry enable |
| devslp | output | 1 | Device-sleep sideband output |
| exit_ready | output | 1 | One-cycle pulse when the exit window ends |

## Verification
The assertions assume that `cfg_min_hold` and `cfg_exit_win` stay constant while DEVSLP is high or the exit window is running. They also assume that the tick and request inputs are single-cycle pulses. The stimulus changes the timing fields only while the controller is awake and `port_idle` is low. It drives every tick, sleep pulse and wake pulse for exactly one cycle. Only the automatic-enable bit is toggled during sleep, and that is deliberate, because it is itself a release condition. Ticks are spaced four cycles apart, so every transition settles before the next tick arrives.

// File: rtl/devslp_pkg.sv
package devslp_pkg;

    typedef enum logic [2:0] {
        DS_ACTIVE       = 3'd0,
        DS_IDLE_COUNT   = 3'd1,
        DS_ASSERTED_MIN = 3'd2,
        DS_ASSERTED     = 3'd3,
        DS_EXITING      = 3'd4
    } dslp_state_e;

    typedef struct packed {
        dslp_state_e state;
        logic        devslp;
        logic        exit_ready;
        logic        release_pend;
        logic        auto_prev;
    } dslp_regs_t;

endpackage

// File: rtl/devslp_tick_counter.sv
module devslp_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         reach
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign reach = (cnt_q >= limit);

    // The count moves by one step per tick at most, and returns to zero when cleared.
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> (cnt_q == $past(cnt_q)));
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/devslp_idle_target.sv
module devslp_idle_target #(
    parameter int CNT_W  = 10,
    parameter int MULT_W = 4,
    localparam int TGT_W = CNT_W + MULT_W
) (
    input  logic [CNT_W-1:0]  idle_cnt,
    input  logic [MULT_W-1:0] idle_mult,
    output logic [TGT_W-1:0]  target
);
    logic [MULT_W:0] factor;

    always_comb begin
        factor = {1'b0, idle_mult} + (MULT_W + 1)'(1);
        target = TGT_W'(idle_cnt) * TGT_W'(factor);
    end

endmodule

// File: rtl/devslp_timeout_ctrl.sv
module devslp_timeout_ctrl
    import devslp_pkg::*;
#(
    parameter int IDLE_W = 10,
    parameter int MULT_W = 4,
    parameter int HOLD_W = 5,
    parameter int EXIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              port_idle,
    input  logic              sw_sleep_req,
    input  logic              sw_wake_req,
    input  logic [IDLE_W-1:0] cfg_idle_cnt,
    input  logic [MULT_W-1:0] cfg_idle_mult,
    input  logic [HOLD_W-1:0] cfg_min_hold,
    input  logic [EXIT_W-1:0] cfg_exit_win,
    input  logic              cfg_platform_ok,
    input  logic              cfg_auto_en,
    output logic              devslp,
    output logic              exit_ready
);
    localparam int TGT_W = IDLE_W + MULT_W;

    dslp_regs_t cur_q, nx_d;

    logic [TGT_W-1:0] idle_target;
    logic             idle_reach, hold_reach, exit_reach;
    logic             idle_clr, hold_clr, exit_clr;
    logic             auto_ok, auto_fall, awake;

    assign auto_ok   = cfg_platform_ok && cfg_auto_en;
    assign auto_fall = cur_q.auto_prev && !cfg_auto_en;
    assign awake     = (cur_q.state == DS_ACTIVE) || (cur_q.state == DS_IDLE_COUNT);

    assign idle_clr = !(port_idle && auto_ok && awake);
    assign hold_clr = !((cur_q.state == DS_ASSERTED_MIN) || (cur_q.state == DS_ASSERTED));
    assign exit_clr = (cur_q.state != DS_EXITING);

    devslp_idle_target #(.CNT_W(IDLE_W), .MULT_W(MULT_W)) tgt_i (
        .idle_cnt  (cfg_idle_cnt),
        .idle_mult (cfg_idle_mult),
        .target    (idle_target)
    );

    devslp_tick_counter #(.W(TGT_W)) idle_ctr_i (
        .clk (clk), .rst_n (rst_n), .clear (idle_clr), .tick (tick_ms),
        .limit (idle_target), .reach (idle_reach)
    );

    devslp_tick_counter #(.W(HOLD_W)) hold_ctr_i (
        .clk (clk), .rst_n (rst_n), .clear (hold_clr), .tick (tick_ms),
        .limit (cfg_min_hold), .reach (hold_reach)
    );

    devslp_tick_counter #(.W(EXIT_W)) exit_ctr_i (
        .clk (clk), .rst_n (rst_n), .clear (exit_clr), .tick (tick_ms),
        .limit (cfg_exit_win), .reach (exit_reach)
    );

    always_comb begin
        logic rel;
        nx_d            = cur_q;
        nx_d.exit_ready = 1'b0;
        nx_d.auto_prev  = cfg_auto_en;
        rel             = cur_q.release_pend || sw_wake_req || auto_fall;

        unique case (cur_q.state)
            DS_ACTIVE: begin
                if (sw_sleep_req) begin
                    nx_d.state = DS_ASSERTED_MIN;
                end else if (port_idle && auto_ok) begin
                    nx_d.state = idle_reach ? DS_ASSERTED_MIN : DS_IDLE_COUNT;
                end
            end
            DS_IDLE_COUNT: begin
                if (sw_sleep_req) begin
                    nx_d.state = DS_ASSERTED_MIN;
                end else if (!(port_idle && auto_ok)) begin
                    nx_d.state = DS_ACTIVE;
                end else if (idle_reach) begin
                    nx_d.state = DS_ASSERTED_MIN;
                end
            end
            DS_ASSERTED_MIN: begin
                if (hold_reach) begin
                    nx_d.state        = rel ? DS_EXITING : DS_ASSERTED;
                    nx_d.release_pend = 1'b0;
                end else begin
                    nx_d.release_pend = rel;
                end
            end
            DS_ASSERTED: begin
                if (sw_wake_req || auto_fall) begin
                    nx_d.state = DS_EXITING;
                end
            end
            DS_EXITING: begin
                if (exit_reach) begin
                    nx_d.state      = DS_ACTIVE;
                    nx_d.exit_ready = 1'b1;
                end
            end
            default: nx_d.state = DS_ACTIVE;
        endcase

        nx_d.devslp = (nx_d.state == DS_ASSERTED_MIN) || (nx_d.state == DS_ASSERTED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: DS_ACTIVE, devslp: 1'b0, exit_ready: 1'b0,
                       release_pend: 1'b0, auto_prev: 1'b0};
        end else begin
            cur_q <= nx_d;
        end
    end

    assign devslp     = cur_q.devslp;
    assign exit_ready = cur_q.exit_ready;

    // R1: a rise comes from a software request or from a completed idle count.
    p_rise_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devslp) |-> ($past(sw_sleep_req) || $past(idle_reach)));
    // R3: DEVSLP only falls after the hold counter reports its limit.
    p_min_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devslp) |-> $past(hold_reach));
    // R4: a rise without a software request needs the automatic path to be allowed.
    p_auto_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(devslp) && !$past(sw_sleep_req)) |-> $past(cfg_platform_ok && cfg_auto_en));
    // R7: the ready strobe lasts one cycle and is seen with DEVSLP low.
    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exit_ready |=> !exit_ready);
    p_ready_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exit_ready |-> !devslp);
    // R8: a sleep request inside the exit window does not raise DEVSLP.
    p_exit_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == DS_EXITING) && sw_sleep_req) |=> !devslp);

endmodule

// File: tb/devslp_timeout_ctrl_tb_top.sv
module devslp_timeout_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       port_idle = 1'b0;
    logic       sw_sleep_req = 1'b0;
    logic       sw_wake_req = 1'b0;
    logic [9:0] cfg_idle_cnt = 10'd4;
    logic [3:0] cfg_idle_mult = 4'hF;
    logic [4:0] cfg_min_hold = 5'd10;
    logic [7:0] cfg_exit_win = 8'd20;
    logic       cfg_platform_ok = 1'b1;
    logic       cfg_auto_en = 1'b0;
    logic       devslp;
    logic       exit_ready;

    int n_checks = 0;
    int n_fails  = 0;
    int ready_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    devslp_timeout_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .tick_ms (tick_ms), .port_idle (port_idle),
        .sw_sleep_req (sw_sleep_req), .sw_wake_req (sw_wake_req),
        .cfg_idle_cnt (cfg_idle_cnt), .cfg_idle_mult (cfg_idle_mult),
        .cfg_min_hold (cfg_min_hold), .cfg_exit_win (cfg_exit_win),
        .cfg_platform_ok (cfg_platform_ok), .cfg_auto_en (cfg_auto_en),
        .devslp (devslp), .exit_ready (exit_ready)
    );

    always @(negedge clk) if (rst_n && exit_ready) ready_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_sleep();
        @(negedge clk) sw_sleep_req = 1'b1;
        @(negedge clk) sw_sleep_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_wake();
        @(negedge clk) sw_wake_req = 1'b1;
        @(negedge clk) sw_wake_req = 1'b0;
        @(negedge clk);
    endtask

    // Ticks with DEVSLP high, then ticks until the ready strobe.
    task automatic hold_and_exit(input int exp_hold, input int exp_exit);
        int m = 0;
        int e = 0;
        while (devslp && m < 100) begin tick_once(); m++; end
        chk("R3 hold ticks", m, exp_hold);
        ready_cnt = 0;
        while (ready_cnt == 0 && e < 300) begin tick_once(); e++; end
        chk("R7 exit ticks", e, exp_exit);
        chk("R7 single pulse", ready_cnt, 1);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_fails++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R9 devslp after reset", int'(devslp), 0);
        chk("R9 exit_ready after reset", int'(exit_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: automatic entry disabled by the enable bit, then by the platform flag.
        cfg_idle_cnt = 10'd2; cfg_idle_mult = 4'd0;
        cfg_auto_en = 1'b0; cfg_platform_ok = 1'b1; port_idle = 1'b1;
        for (int i = 0; i < 10; i++) tick_once();
        chk("R4 auto_en=0 stays awake", int'(devslp), 0);
        cfg_auto_en = 1'b1; cfg_platform_ok = 1'b0;
        for (int i = 0; i < 10; i++) tick_once();
        chk("R4 platform_ok=0 stays awake", int'(devslp), 0);
        port_idle = 1'b0; cfg_platform_ok = 1'b1;
        @(negedge clk);

        // R1 sweep of count, multiplier, hold and exit window.
        for (int ic = 1; ic <= 3; ic++) begin
            for (int mu = 0; mu <= 2; mu++) begin
                for (int mh = 1; mh <= 3; mh++) begin
                    cfg_idle_cnt = 10'(ic); cfg_idle_mult = 4'(mu);
                    cfg_min_hold = 5'(mh); cfg_exit_win = 8'(ic + mu);
                    @(negedge clk) port_idle = 1'b1;
                    n = 0;
                    while (!devslp && n < 200) begin tick_once(); n++; end
                    chk("R1 idle ticks to entry", n, ic * (mu + 1));
                    port_idle = 1'b0;
                    pulse_wake();
                    chk("R3 early wake keeps devslp", int'(devslp), 1);
                    hold_and_exit(mh, ic + mu);
                end
            end
        end

        // R2: idle loss restarts the count.
        cfg_idle_cnt = 10'd3; cfg_idle_mult = 4'd1; cfg_min_hold = 5'd1; cfg_exit_win = 8'd1;
        @(negedge clk) port_idle = 1'b1;
        for (int i = 0; i < 4; i++) tick_once();
        chk("R2 no entry before target", int'(devslp), 0);
        @(negedge clk) port_idle = 1'b0;
        @(negedge clk) port_idle = 1'b1;
        n = 0;
        while (!devslp && n < 200) begin tick_once(); n++; end
        chk("R2 full count after restart", n, 6);
        port_idle = 1'b0;
        pulse_wake();
        hold_and_exit(1, 1);

        // R5 and R6: software entry with auto path off, release by auto_en falling.
        cfg_auto_en = 1'b0; cfg_platform_ok = 1'b0; cfg_min_hold = 5'd2; cfg_exit_win = 8'd3;
        pulse_sleep();
        chk("R5 software entry", int'(devslp), 1);
        cfg_auto_en = 1'b1;
        tick_once(); tick_once();
        tick_once();
        chk("R6 no release without request", int'(devslp), 1);
        @(negedge clk) cfg_auto_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R6 auto_en fall releases", int'(devslp), 0);
        ready_cnt = 0;
        n = 0;
        while (ready_cnt == 0 && n < 300) begin tick_once(); n++; end
        chk("R7 exit after auto release", n, 3);

        // R3: auto_en falling during the hold is deferred.
        cfg_min_hold = 5'd3; cfg_exit_win = 8'd2; cfg_platform_ok = 1'b1;
        pulse_sleep();
        chk("R5 second software entry", int'(devslp), 1);
        @(negedge clk) cfg_auto_en = 1'b1;
        @(negedge clk) cfg_auto_en = 1'b0;
        @(negedge clk);
        chk("R3 deferred auto release", int'(devslp), 1);
        hold_and_exit(3, 2);

        // R8: sleep request inside the exit window.
        cfg_min_hold = 5'd1; cfg_exit_win = 8'd4;
        pulse_sleep();
        tick_once();
        pulse_wake();
        chk("R6 wake after hold", int'(devslp), 0);
        ready_cnt = 0;
        tick_once();
        pulse_sleep();
        chk("R8 sleep ignored in exit", int'(devslp), 0);
        n = 1;
        while (ready_cnt == 0 && n < 300) begin tick_once(); n++; end
        chk("R8 exit window unchanged", n, 4);
        chk("R8 still awake after exit", int'(devslp), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule